// File: doc/BRIEF.md
# Time-of-Day Clock with Serialized Store

This block keeps a 64-bit time-of-day count and answers store-clock requests. The count runs at one increment of the microsecond weight per `us_tick` pulse. With bits numbered from the most significant end as bit 0, bit 51 is the microsecond bit and bit 31 steps every 2^20 microseconds. A four-state status register qualifies the count, and software commands can set or change it. A read returns the count together with a 2-bit condition code that reports how trustworthy the count is. Low-order bit positions that the clock does not implement always read as zero.

A store request enters on a valid/ready pair. `store_req_ready` is high only while no store is in progress. Once the block accepts a request, it waits for `drain_done`, which reports that all earlier storage accesses have completed. In that cycle it samples the clock. It then presents the result with `store_valid` and holds the value and condition code unchanged until `store_ready` is seen. The consumer can apply back-pressure for any number of cycles. The block accepts no new request until that handshake completes, so later fetches stay ordered behind the stored value.

Top module: `tod_clock_store`

## Requirements
- R1: After reset the count is zero, the status is not-set (condition code 1), `store_req_ready` is 1 and `store_valid` is 0.
- R2: In the set or not-set status, each cycle with `us_tick` high adds 4096 (vector bit 12, the MSB-numbered bit 51) to the count, and the count wraps modulo 2^64.
- R3: In the error or not-operational status, the count does not change on ticks.
- R4: `set_valid` loads `set_value` and enters the set status. It takes priority over a state command and a tick in the same cycle.
- R5: `state_cmd_valid` writes `state_cmd` into the status and leaves the count unchanged.
- R6: The condition code equals the status encoding: set = 0, not-set = 1, error = 2, not-operational = 3.
- R7: When the condition code is 2 or 3, the stored value is all zeros.
- R8: Vector bits [W-IMPL_BITS-1:0] of the stored value are zero. With the defaults this is bits [7:0].
- R9: The clock is sampled at the clock edge where `drain_done` is high while a request is waiting. `store_valid` stays low until then, and ticks that arrive before that edge are included in the value.
- R10: `store_valid` stays high, with the value and condition code stable, until `store_ready`. `store_req_ready` stays low from acceptance until that final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-microsecond advance enable |
| set_valid | input | 1 | Load `set_value` and enter set status |
| set_value | input | 64 | Value to load |
| state_cmd_valid | input | 1 | Write `state_cmd` into the status |
| state_cmd | input | 2 | New status (0 set, 1 not-set, 2 error, 3 not-operational) |
| store_req_valid | input | 1 | Store request valid |
| store_req_ready | output | 1 | Request can be accepted |
| drain_done | input | 1 | Earlier storage accesses have completed |
| store_valid | output | 1 | Stored value and code are presented |
| store_ready | input | 1 | Consumer takes the stored value |
| store_value | output | 64 | Masked clock value |
| store_cc | output | 2 | Condition code |

## Verification
The hardest case to reach is a request that has been accepted but whose drain has not yet arrived, while the count is still moving. The sample must come from the drain edge and not from the acceptance edge. The bench accepts a request, keeps `drain_done` low while ticks arrive for several cycles, and then raises it. It expects the later count. It then holds `store_ready` low while ticks continue and new requests are offered, to show that the presented value is frozen and that no second request is accepted.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    TOD_SET     = 2'd0,
    TOD_UNSET   = 2'd1,
    TOD_FAULT   = 2'd2,
    TOD_OFFLINE = 2'd3
  } tod_state_e;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_DRAIN = 2'd1,
    RD_HOLD  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int W        = 64,
  parameter int TICK_POS = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         us_tick,
  input  logic         set_valid,
  input  logic [W-1:0] set_value,
  input  logic         state_cmd_valid,
  input  logic [1:0]   state_cmd,
  output logic [W-1:0] count_q,
  output tod_state_e   state_q
);
  localparam logic [W-1:0] STEP = W'(1) << TICK_POS;

  logic running;
  assign running = (state_q == TOD_SET) || (state_q == TOD_UNSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      state_q <= TOD_UNSET;
    end else if (set_valid) begin
      count_q <= set_value;
      state_q <= TOD_SET;
    end else begin
      if (state_cmd_valid) state_q <= tod_state_e'(state_cmd);
      if (us_tick && running) count_q <= count_q + STEP;
    end
  end
endmodule

// File: rtl/tod_read_mask.sv
module tod_read_mask
  import tod_pkg::*;
#(
  parameter int W         = 64,
  parameter int IMPL_BITS = 56
) (
  input  logic [W-1:0] count,
  input  tod_state_e   state,
  output logic [W-1:0] value,
  output logic [1:0]   cc
);
  localparam int LOW_ZERO = W - IMPL_BITS;

  logic [W-1:0] keep;
  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep[i] = (i >= LOW_ZERO);
  end

  logic usable;
  assign usable = (state == TOD_SET) || (state == TOD_UNSET);
  assign value  = usable ? (count & keep) : '0;
  assign cc     = state;
endmodule

// File: rtl/tod_store_fsm.sv
module tod_store_fsm
  import tod_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         drain_done,
  input  logic [W-1:0] sample_value,
  input  logic [1:0]   sample_cc,
  output logic         resp_valid,
  input  logic         resp_ready,
  output logic [W-1:0] resp_value,
  output logic [1:0]   resp_cc
);
  rd_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RD_IDLE;
      resp_value <= '0;
      resp_cc    <= 2'd0;
    end else begin
      case (st_q)
        RD_IDLE:  if (req_valid) st_q <= RD_DRAIN;
        RD_DRAIN: if (drain_done) begin
          resp_value <= sample_value;
          resp_cc    <= sample_cc;
          st_q       <= RD_HOLD;
        end
        RD_HOLD:  if (resp_ready) st_q <= RD_IDLE;
        default:  st_q <= RD_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == RD_IDLE);
  assign resp_valid = (st_q == RD_HOLD);
endmodule

// File: rtl/tod_clock_store.sv
module tod_clock_store
  import tod_pkg::*;
#(
  parameter int W         = 64,
  parameter int IMPL_BITS = 56,
  parameter int TICK_POS  = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         us_tick,
  input  logic         set_valid,
  input  logic [W-1:0] set_value,
  input  logic         state_cmd_valid,
  input  logic [1:0]   state_cmd,
  input  logic         store_req_valid,
  output logic         store_req_ready,
  input  logic         drain_done,
  output logic         store_valid,
  input  logic         store_ready,
  output logic [W-1:0] store_value,
  output logic [1:0]   store_cc
);
  logic [W-1:0] count_q;
  tod_state_e   state_q;
  logic [W-1:0] masked_value;
  logic [1:0]   masked_cc;

  tod_counter #(.W(W), .TICK_POS(TICK_POS)) u_counter (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .set_valid(set_valid), .set_value(set_value),
    .state_cmd_valid(state_cmd_valid), .state_cmd(state_cmd),
    .count_q(count_q), .state_q(state_q)
  );

  tod_read_mask #(.W(W), .IMPL_BITS(IMPL_BITS)) u_mask (
    .count(count_q), .state(state_q), .value(masked_value), .cc(masked_cc)
  );

  tod_store_fsm #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .req_valid(store_req_valid), .req_ready(store_req_ready),
    .drain_done(drain_done),
    .sample_value(masked_value), .sample_cc(masked_cc),
    .resp_valid(store_valid), .resp_ready(store_ready),
    .resp_value(store_value), .resp_cc(store_cc)
  );
endmodule

// File: rtl/tod_clock_store_chk.sv
module tod_clock_store_chk #(
  parameter int W         = 64,
  parameter int IMPL_BITS = 56,
  parameter int TICK_POS  = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         us_tick,
  input logic         set_valid,
  input logic [W-1:0] set_value,
  input logic [W-1:0] count_q,
  input logic [1:0]   state_q,
  input logic         store_req_ready,
  input logic         store_valid,
  input logic         store_ready,
  input logic [W-1:0] store_value,
  input logic [1:0]   store_cc
);
  localparam logic [W-1:0] STEP = W'(1) << TICK_POS;

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (us_tick && !set_valid && !state_q[1]) |=> (count_q == $past(count_q) + STEP));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[1] && !set_valid) |=> $stable(count_q));

  assert_set_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> (state_q == 2'd0 && count_q == $past(set_value)));

  assert_zero_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && store_cc[1]) |-> (store_value == '0));

  if (IMPL_BITS < W) begin : g_low
    assert_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      store_valid |-> (store_value[W-IMPL_BITS-1:0] == '0));
  end

  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_valid |-> !store_req_ready);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && !store_ready) |=>
      (store_valid && $stable(store_value) && $stable(store_cc)));
endmodule

bind tod_clock_store tod_clock_store_chk #(
  .W(W), .IMPL_BITS(IMPL_BITS), .TICK_POS(TICK_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
  .set_valid(set_valid), .set_value(set_value),
  .count_q(count_q), .state_q(state_q),
  .store_req_ready(store_req_ready), .store_valid(store_valid),
  .store_ready(store_ready), .store_value(store_value), .store_cc(store_cc)
);

// File: tb/test_tod_clock_store.sv
`timescale 1ns/1ps
module test_tod_clock_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        set_valid = 1'b0;
  logic [63:0] set_value = '0;
  logic        state_cmd_valid = 1'b0;
  logic [1:0]  state_cmd = 2'd0;
  logic        store_req_valid = 1'b0;
  logic        store_req_ready;
  logic        drain_done = 1'b0;
  logic        store_valid;
  logic        store_ready = 1'b0;
  logic [63:0] store_value;
  logic [1:0]  store_cc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tod_clock_store i_tod_clock_store (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .set_valid(set_valid), .set_value(set_value),
    .state_cmd_valid(state_cmd_valid), .state_cmd(state_cmd),
    .store_req_valid(store_req_valid), .store_req_ready(store_req_ready),
    .drain_done(drain_done), .store_valid(store_valid),
    .store_ready(store_ready), .store_value(store_value), .store_cc(store_cc)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung act=%0d cycles exp=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_set(input logic [63:0] v);
    @(negedge clk); set_valid = 1'b1; set_value = v;
    @(negedge clk); set_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] s);
    @(negedge clk); state_cmd_valid = 1'b1; state_cmd = s;
    @(negedge clk); state_cmd_valid = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    @(negedge clk); us_tick = 1'b1;
    repeat (n) @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic do_store(output logic [63:0] v, output logic [1:0] c);
    @(negedge clk); store_req_valid = 1'b1;
    @(negedge clk); store_req_valid = 1'b0; drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0;
    chk("R10 valid presented", 64'(store_valid), 64'd1);
    v = store_value; c = store_cc;
    store_ready = 1'b1;
    @(negedge clk); store_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [63:0] setv;
    logic        cmd_en;
    logic [1:0]  cmd;
    logic [3:0]  ticks;
    logic [63:0] expv;
    logic [1:0]  expc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'h0123_4567_89AB_CDEF, 1'b0, 2'd0, 4'd0, 64'h0123_4567_89AB_CD00, 2'd0},
    '{64'h0000_0000_0000_00FF, 1'b1, 2'd1, 4'd2, 64'h0000_0000_0000_2000, 2'd1},
    '{64'hFFFF_FFFF_FFFF_F000, 1'b0, 2'd0, 4'd1, 64'h0000_0000_0000_0000, 2'd0},
    '{64'h1234_0000_0000_0000, 1'b1, 2'd2, 4'd3, 64'h0000_0000_0000_0000, 2'd2},
    '{64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 2'd3, 4'd0, 64'h0000_0000_0000_0000, 2'd3},
    '{64'h0000_0000_000F_F0FF, 1'b0, 2'd0, 4'd1, 64'h0000_0000_0010_0000, 2'd0}
  };

  logic [63:0] v;
  logic [1:0]  c;
  logic [63:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", 64'(store_req_ready), 64'd1);
    chk("R1 store_valid", 64'(store_valid), 64'd0);
    do_store(v, c);
    chk("R1 value", v, 64'd0);
    chk("R1 cc not-set", 64'(c), 64'd1);

    // Vector table: R2 ticks/wrap, R5/R6 codes, R7 zero on fault, R8 low bits
    foreach (VECS[i]) begin
      do_set(VECS[i].setv);
      if (VECS[i].cmd_en) do_cmd(VECS[i].cmd);
      if (VECS[i].ticks != 0) do_ticks(int'(VECS[i].ticks));
      do_store(v, c);
      chk($sformatf("R2/R7/R8 vector %0d value", i), v, VECS[i].expv);
      chk($sformatf("R6 vector %0d cc", i), 64'(c), 64'(VECS[i].expc));
    end

    // R3 frozen in error, R5 command keeps count
    do_set(64'h0000_0000_0000_5000);
    do_cmd(2'd2);
    do_ticks(4);
    do_cmd(2'd1);
    do_store(v, c);
    chk("R3 count frozen in error", v, 64'h5000);
    chk("R5 cc after state cmd", 64'(c), 64'd1);

    // R4 set beats state cmd and tick in same cycle
    @(negedge clk);
    set_valid = 1'b1; set_value = 64'h7700; state_cmd_valid = 1'b1; state_cmd = 2'd3; us_tick = 1'b1;
    @(negedge clk);
    set_valid = 1'b0; state_cmd_valid = 1'b0; us_tick = 1'b0;
    do_store(v, c);
    chk("R4 set priority value", v, 64'h7700);
    chk("R4 set priority cc", 64'(c), 64'd0);

    // R9 sample waits for drain; ticks during wait included
    do_set(64'h0000_0000_0001_0000);
    @(negedge clk); store_req_valid = 1'b1;
    @(negedge clk); store_req_valid = 1'b0; us_tick = 1'b1;
    chk("R10 req_ready low while waiting", 64'(store_req_ready), 64'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 no valid before drain", 64'(store_valid), 64'd0);
    end
    us_tick = 1'b0; drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0;
    chk("R9 valid after drain", 64'(store_valid), 64'd1);
    chk("R9 value sampled at drain", store_value, 64'h0000_0000_0001_3000);
    held = store_value;

    // R10 back-pressure: value stable, no new request accepted
    us_tick = 1'b1; store_req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R10 valid held", 64'(store_valid), 64'd1);
      chk("R10 value stable", store_value, held);
      chk("R10 req_ready low", 64'(store_req_ready), 64'd0);
    end
    us_tick = 1'b0; store_req_valid = 1'b0; store_ready = 1'b1;
    @(negedge clk); store_ready = 1'b0;
    chk("R10 valid drops after ack", 64'(store_valid), 64'd0);
    chk("R10 req_ready back", 64'(store_req_ready), 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule